// File: doc/BRIEF.md
# Double-Buffered Register Update Controller

This block keeps two copies of a small bank of programming registers. Every write lands in a holding copy. The active copy, which drives the rest of the datapath, takes all holding values at once, and only when an update event happens. This lets a multi-word setting, such as a new frequency together with a new phase, take effect on a single clock edge.

An update event has one of two sources. The first is an internal interval timer that reloads from a programmable period. The second is a rising edge on a shared update pin. A mode bit picks the source and also sets the direction of the pin:
- In internal mode the pin is an output. It emits a fixed-width high pulse for every transfer.
- In external mode the pin is an input. It is synchronized and then edge-detected.

The two modes have different fixed latencies from event to transfer. Reset selects internal mode with the pin driven as an output.

Top module: `dbuf_update_ctrl`

## Requirements
- R1: After reset, every active register holds its reset value from `RST_VALS`. Register i holds bits [i*DW +: DW]. Also after reset, `upd_pin_oe` is 1 and `upd_pin_o` is 0.
- R2: A write to address i (`wr_en`=1, `wr_addr`=i) changes only holding register i. The active outputs do not change until an update event.
- R3: Internal mode is selected by `cfg_ext_mode`=0. In this mode an update occurs every `period`+1 clocks, and `upd_pin_o` rises once for each update.
- R4: Each indication pulse on `upd_pin_o` stays high for exactly `PULSE_LEN` clocks, which is 8 by default, provided no new update occurs inside the pulse.
- R5: In internal mode the active registers take the holding values one clock after `upd_pin_o` rises. This is two clocks after the timer expires.
- R6: External mode is selected by `cfg_ext_mode`=1. In this mode `upd_pin_oe` and `upd_pin_o` are 0. The active registers take the holding values on the third rising clock edge after the first edge that samples `upd_pin_i` high.
- R7: In external mode only a rising edge of `upd_pin_i` causes a transfer. Holding the pin high does not cause further transfers.
- R8: In internal mode `upd_pin_i` is ignored. A pulse on it transfers nothing.
- R9: A write captured on the same edge as a transfer goes into the holding register only. The active register receives the value the holding register had before that write.
- R10: A single update transfers all holding registers together, including writes made several updates earlier.
- R11: A configuration write (`cfg_we`=1) loads the period and restarts the timer. In internal mode the first `upd_pin_o` rise follows the configuration edge by `period`+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe into the holding registers |
| wr_addr | input | AW | Holding register index |
| wr_data | input | DW | Write data |
| cfg_we | input | 1 | Loads the mode bit and period, and restarts the timer |
| cfg_ext_mode | input | 1 | 0: internal timer with the pin as output; 1: external pin edge |
| cfg_period | input | TW | Timer reload value |
| upd_pin_i | input | 1 | Update pin, input side |
| upd_pin_o | output | 1 | Update pin, output side (transfer indication pulse) |
| upd_pin_oe | output | 1 | Update pin output enable |
| active_regs | output | NREG*DW | Active register bank, register i at bits [i*DW +: DW] |

## Verification
Some properties are checked by assertions on every cycle:
- Without a load strobe, the active bank never moves.
- The edge detector never fires on two consecutive cycles.
- The timer produces no event in external mode, and a pin edge never produces a transfer in internal mode.
- An indication pulse starts only on a timer trigger and never falls before `PULSE_LEN` high cycles.

Other behaviours only the bench scenarios can show:
- The exact latencies of two and three clocks.
- The `period`+1 spacing after a configuration write.
- A write that collides with a transfer.
- A pin held high that must not transfer twice.

// File: rtl/upd_pkg.sv
// Package: shared types for the double-buffered update controller.
// Assumes: a single mode bit selects both the pin direction and the event source.
package upd_pkg;

    // Source of update events; also decides who drives the update pin.
    typedef enum logic {
        MODE_INT = 1'b0,   // internal timer, pin driven as output
        MODE_EXT = 1'b1    // external pin edge, pin is an input
    } upd_mode_e;

endpackage

// File: rtl/upd_pin_sync.sv
// Module: upd_pin_sync
// Brings the asynchronous update pin into the clock domain through a
// STAGES-deep flop chain and flags its rising edge for one cycle.
// Assumes: the pin is stable for at least two clocks per level.
module upd_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    logic [STAGES:0] sh_q;

    // Shift the pin through the synchronizer chain plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], pin_i};
    end

    // Rising edge: newest synchronized sample high, previous one low.
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R7: an edge lasts one cycle, so a held level cannot retrigger.
    p_single_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/upd_timer.sv
// Module: upd_timer
// Down-counter that reloads from a stored period and flags expiry once
// per period+1 clocks while running. A reload request restarts it.
// Assumes: reload has priority over counting.
module upd_timer #(
    parameter int              TW         = 32,
    parameter logic [TW-1:0]   RST_PERIOD = TW'(99)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          reload_i,
    input  logic [TW-1:0] period_i,
    output logic          expire_o
);

    logic [TW-1:0] per_q;
    logic [TW-1:0] cnt_q;

    // Hold the period and count down, reloading at zero or on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= RST_PERIOD;
            cnt_q <= RST_PERIOD;
        end else if (reload_i) begin
            per_q <= period_i;
            cnt_q <= period_i;
        end else if (run_i) begin
            cnt_q <= (cnt_q == '0) ? per_q : cnt_q - TW'(1);
        end
    end

    // Expiry is reported in the cycle the count sits at zero.
    assign expire_o = run_i & ~reload_i & (cnt_q == '0);

endmodule

// File: rtl/upd_pulse_gen.sv
// Module: upd_pulse_gen
// Stretches a one-cycle trigger into a LEN-cycle high pulse starting on
// the edge after the trigger. A new trigger restarts the pulse.
// Assumes: LEN >= 1.
module upd_pulse_gen #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;
    int unsigned   hi_run_q;

    // Load the width on a trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (trig_i)       cnt_q <= CW'(LEN);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end

    assign pulse_o = (cnt_q != '0);

    // Checker counter: consecutive cycles the pulse has been high.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_run_q <= 0;
        else if (pulse_o) hi_run_q <= hi_run_q + 1;
        else              hi_run_q <= 0;
    end

    // R3: a pulse only starts because of a trigger.
    p_pulse_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(trig_i));

    // R4: a pulse never ends before LEN high cycles.
    p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_o) |-> (hi_run_q >= LEN));

endmodule

// File: rtl/upd_regfile.sv
// Module: upd_regfile
// Bank of NREG holding/active register pairs. Writes go to the holding
// copy; a load strobe copies every holding value to the active copy.
// Assumes: addresses at or above NREG are dropped.
module upd_regfile #(
    parameter int                    NREG     = 4,
    parameter int                    DW       = 16,
    parameter int                    AW       = (NREG > 1) ? $clog2(NREG) : 1,
    parameter logic [NREG*DW-1:0]    RST_VALS = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               load_i,
    output logic [NREG*DW-1:0] act_o
);

    logic [DW-1:0] hold_q [NREG];
    logic [DW-1:0] act_q  [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Holding copy takes writes; active copy takes the holding copy on load.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[g] <= RST_VALS[g*DW +: DW];
                act_q[g]  <= RST_VALS[g*DW +: DW];
            end else begin
                if (wr_en && (wr_addr == AW'(g))) hold_q[g] <= wr_data;
                if (load_i)                        act_q[g]  <= hold_q[g];
            end
        end
        assign act_o[g*DW +: DW] = act_q[g];
    end

    // R2: without a load strobe the active bank holds its value.
    p_active_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(act_o));

endmodule

// File: rtl/dbuf_update_ctrl.sv
// Module: dbuf_update_ctrl (top)
// Double-buffered register update controller. Update events come from the
// internal timer (pin driven as indication output) or from a synchronized
// rising edge on the update pin (pin as input). One register stage joins
// both sources ahead of the load, giving 2 clocks from timer expiry and
// 3 clocks from the first pin sampling edge to the transfer.
// Assumes: the pin's tristate buffer is outside this block.
module dbuf_update_ctrl
    import upd_pkg::*;
#(
    parameter int                  NREG       = 4,
    parameter int                  DW         = 16,
    parameter int                  AW         = (NREG > 1) ? $clog2(NREG) : 1,
    parameter int                  TW         = 32,
    parameter int                  PULSE_LEN  = 8,
    parameter int                  SYNC_STG   = 2,
    parameter logic [TW-1:0]       RST_PERIOD = TW'(99),
    parameter logic [NREG*DW-1:0]  RST_VALS   = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic               cfg_we,
    input  logic               cfg_ext_mode,
    input  logic [TW-1:0]      cfg_period,
    input  logic               upd_pin_i,
    output logic               upd_pin_o,
    output logic               upd_pin_oe,
    output logic [NREG*DW-1:0] active_regs
);

    upd_mode_e mode_q;
    logic      pin_rise;
    logic      int_evt;
    logic      ext_evt;
    logic      evt_q;
    logic      pulse;

    // Mode bit register; reset selects the internal timer.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= MODE_INT;
        else if (cfg_we) mode_q <= upd_mode_e'(cfg_ext_mode);
    end

    upd_pin_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (upd_pin_i),
        .rise_o (pin_rise)
    );

    upd_timer #(.TW(TW), .RST_PERIOD(RST_PERIOD)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (mode_q == MODE_INT),
        .reload_i (cfg_we),
        .period_i (cfg_period),
        .expire_o (int_evt)
    );

    assign ext_evt = pin_rise & (mode_q == MODE_EXT);

    // Common event stage ahead of the bank load.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= int_evt | ext_evt;
    end

    upd_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (int_evt),
        .pulse_o (pulse)
    );

    upd_regfile #(.NREG(NREG), .DW(DW), .AW(AW), .RST_VALS(RST_VALS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load_i  (evt_q),
        .act_o   (active_regs)
    );

    assign upd_pin_oe = (mode_q == MODE_INT);
    assign upd_pin_o  = pulse & (mode_q == MODE_INT);

    // R8: the timer is silent while the pin owns the event source.
    p_ext_timer_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_EXT) |-> !int_evt);

    // R8: in internal mode only the timer can schedule a transfer.
    p_pin_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_INT) && !int_evt) |=> !evt_q);

endmodule

// File: tb/sim_dbuf_update_ctrl.sv
// Bench for dbuf_update_ctrl: vector table in external mode, then directed
// latency, level-hold, internal-timer, collision and ignore tests.
module sim_dbuf_update_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 4;
    localparam int DW   = 16;
    localparam int AW   = 2;
    localparam int TW   = 32;
    localparam logic [NREG*DW-1:0] RV = 64'h0123_4567_89AB_CDEF;

    // {fire, addr, data}: write then optionally pulse the pin
    localparam logic [18:0] VEC [0:5] = '{
        {1'b0, 2'd0, 16'h1234},
        {1'b1, 2'd1, 16'hBEEF},
        {1'b0, 2'd2, 16'h5555},
        {1'b0, 2'd3, 16'hAAAA},
        {1'b1, 2'd2, 16'h0F0F},
        {1'b1, 2'd0, 16'hFFFF}
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               wr_en;
    logic [AW-1:0]      wr_addr;
    logic [DW-1:0]      wr_data;
    logic               cfg_we;
    logic               cfg_ext_mode;
    logic [TW-1:0]      cfg_period;
    logic               upd_pin_i;
    logic               upd_pin_o;
    logic               upd_pin_oe;
    logic [NREG*DW-1:0] active_regs;

    int n_vec = 0;
    int n_bad = 0;
    logic [DW-1:0] hold_m [NREG];
    logic [DW-1:0] act_m  [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbuf_update_ctrl #(
        .NREG(NREG), .DW(DW), .AW(AW), .TW(TW), .RST_VALS(RV)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_we(cfg_we), .cfg_ext_mode(cfg_ext_mode),
        .cfg_period(cfg_period), .upd_pin_i(upd_pin_i), .upd_pin_o(upd_pin_o),
        .upd_pin_oe(upd_pin_oe), .active_regs(active_regs)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] model_bus();
        return {act_m[3], act_m[2], act_m[1], act_m[0]};
    endfunction

    function automatic logic [DW-1:0] dut_reg(input int i);
        return active_regs[i*DW +: DW];
    endfunction

    task automatic do_write(input int a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        hold_m[a] = d;
    endtask

    task automatic do_cfg(input logic ext, input logic [TW-1:0] p);
        cfg_we = 1'b1; cfg_ext_mode = ext; cfg_period = p;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fire_pin();
        upd_pin_i = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < NREG; i++) act_m[i] = hold_m[i];
        upd_pin_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int rise1, rise2, width;
        logic prev;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        cfg_we = 1'b0; cfg_ext_mode = 1'b0; cfg_period = '0; upd_pin_i = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            hold_m[i] = RV[i*DW +: DW];
            act_m[i]  = RV[i*DW +: DW];
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 active", active_regs, RV);
        chk("R1 oe", 64'(upd_pin_oe), 64'd1);
        chk("R1 pin_o", 64'(upd_pin_o), 64'd0);

        // Switch to external mode for the vector table
        do_cfg(1'b1, 32'd50);
        chk("R6 oe low in ext", 64'(upd_pin_oe), 64'd0);

        // R2 R6 R10: table walk
        for (int v = 0; v < 6; v++) begin
            do_write(int'(VEC[v][17:16]), VEC[v][15:0]);
            if (VEC[v][18]) fire_pin();
            else repeat (3) @(negedge clk);
            chk(VEC[v][18] ? "R10 bank transfer" : "R2 hold only", active_regs, model_bus());
        end

        // R6: exact external latency
        do_write(0, 16'hA5A5);
        upd_pin_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 not yet at edge 2", 64'(dut_reg(0)), 64'(act_m[0]));
        @(negedge clk);
        act_m[0] = 16'hA5A5;
        chk("R6 loaded at edge 3", 64'(dut_reg(0)), 64'h A5A5);
        chk("R6 pin_o quiet", 64'(upd_pin_o), 64'd0);

        // R7: pin held high does not transfer again
        do_write(1, 16'h1111);
        repeat (6) @(negedge clk);
        chk("R7 level no transfer", 64'(dut_reg(1)), 64'(act_m[1]));
        upd_pin_i = 1'b0;
        repeat (2) @(negedge clk);
        fire_pin();
        chk("R7 new edge transfers", 64'(dut_reg(1)), 64'h1111);

        // Internal mode with period 20
        do_write(0, 16'hC0DE);
        cfg_we = 1'b1; cfg_ext_mode = 1'b0; cfg_period = 32'd20;
        rise1 = -1; rise2 = -1; width = 0; prev = 1'b0;
        for (int k = 0; k <= 70; k++) begin
            @(negedge clk);
            if (k == 0) cfg_we = 1'b0;
            if (upd_pin_o && !prev) begin
                if (rise1 < 0) rise1 = k;
                else if (rise2 < 0) rise2 = k;
            end
            if (upd_pin_o && k < 40) width++;
            prev = upd_pin_o;
            if (k == 5)  chk("R3 oe high in int", 64'(upd_pin_oe), 64'd1);
            if (k == 21) chk("R5 not loaded at pin rise", 64'(dut_reg(0)), 64'(act_m[0]));
            if (k == 22) begin
                for (int i = 0; i < NREG; i++) act_m[i] = hold_m[i];
                chk("R5 loaded one after pin rise", 64'(dut_reg(0)), 64'hC0DE);
            end
            if (k == 30) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h7777; end
            if (k == 31) begin wr_en = 1'b0; hold_m[1] = 16'h7777; end
            if (k == 42) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h9999; end
            if (k == 43) begin
                wr_en = 1'b0;
                act_m[1] = 16'h7777;
                chk("R9 earlier write moved", 64'(dut_reg(1)), 64'h7777);
                chk("R9 colliding write held back", 64'(dut_reg(2)), 64'(act_m[2]));
                hold_m[2] = 16'h9999;
            end
            if (k == 64) begin
                act_m[2] = 16'h9999;
                chk("R9 collided write on next update", 64'(dut_reg(2)), 64'h9999);
            end
        end
        chk("R11 first rise after cfg", 64'(rise1), 64'd21);
        chk("R3 update interval", 64'(rise2 - rise1), 64'd21);
        chk("R4 pulse width", 64'(width), 64'd8);

        // R8: pin ignored in internal mode (long period keeps timer idle)
        do_cfg(1'b0, 32'd1000);
        do_write(3, 16'h3333);
        upd_pin_i = 1'b1;
        repeat (4) @(negedge clk);
        upd_pin_i = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8 pin ignored", 64'(dut_reg(3)), 64'(act_m[3]));
        chk("R8 bank unchanged", active_regs, model_bus());

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule